// File: doc/BRIEF.md
# Pipelined True Dual-Port Memory

This block is a synchronous static memory with two symmetric access ports, A and B. Either port can read or write any word in any cycle, independently of the other. Each port registers its controls, address, write data and lane enables on the clock edge. Write data lands in storage on the following edge. Read data is loaded into an output register on that same following edge. A read therefore becomes visible two edges after its inputs are presented. The word is 18 bits wide and is split into two 9-bit lanes, and each lane has its own enable.

Each port has two select inputs of opposite polarity: `x_cs_n` is active low and `x_cs` is active high. A cycle is selected only when both are asserted. A small per-port state machine controls when the read outputs are driven. It has three states: `PS_DARK` (outputs off), `PS_WAKE` (one selected cycle seen, outputs still off) and `PS_LIVE` (outputs driven). Any unselected cycle sends the machine to `PS_DARK`. From `PS_DARK`, a selected cycle moves it to `PS_WAKE`. From `PS_WAKE`, a selected cycle moves it to `PS_LIVE`. `PS_LIVE` stays in `PS_LIVE` while cycles remain selected. Reset enters `PS_DARK`.

Read output is given as a data bus plus a per-lane valid mask, and lanes that are not driven read as zero. When both ports write the same word in the same cycle, a one-cycle flag is raised. That flag rises on the edge where the writes land.

Top module: `dpr_pipe_ram`

## Requirements
- R1: After reset both valid masks are 00, both data buses are zero, the collision flag is 0, and both output machines are in `PS_DARK`.
- R2: A read presented before edge k is captured at edge k and shows on `x_q`/`x_qv` after edge k+1. The output slot that belongs to a write cycle has `x_qv` = 00.
- R3: A selected read from a live port returns the word last stored at that address.
- R4: A write changes only the lanes whose enable is 1. `x_be[1]` covers bits 17:9 and `x_be[0]` covers bits 8:0. Lanes that are not enabled keep their old contents.
- R5: A read drives only the lanes enabled in its `x_be`. For those lanes `x_qv[i]` = 1. A lane that is not driven has valid 0 and reads as zero.
- R6: A cycle with `x_cs_n` = 1 or `x_cs` = 0 is deselected. Its output slot has `x_qv` = 00, and a write in that cycle changes no memory content.
- R7: After reset or after any deselected cycle, the first selected cycle produces no valid output, even when it is a read. Reads from the second consecutive selected cycle onward are driven.
- R8: Both ports may read the same address in the same cycle, and each receives the stored word.
- R9: When one port writes an address while the other reads it in the same cycle, the read returns the old word. A later read returns the new word.
- R10: `clash` is 1 for exactly the one cycle after the edge where two selected writes to the same address land. It stays 0 for writes to different addresses, and for a write paired with a read or with a deselected cycle.
- R11: On a same-address double write, each lane keeps port A's data if A enabled that lane. Otherwise the lane keeps B's data if B enabled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A operation: 1 write, 0 read |
| a_addr | input | AW | Port A word address |
| a_be | input | 2 | Port A lane enables (bit 1 upper, bit 0 lower) |
| a_d | input | 18 | Port A write data |
| a_q | output | 18 | Port A read data, undriven lanes zero |
| a_qv | output | 2 | Port A per-lane valid mask |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B operation: 1 write, 0 read |
| b_addr | input | AW | Port B word address |
| b_be | input | 2 | Port B lane enables (bit 1 upper, bit 0 lower) |
| b_d | input | 18 | Port B write data |
| b_q | output | 18 | Port B read data, undriven lanes zero |
| b_qv | output | 2 | Port B per-lane valid mask |
| clash | output | 1 | Same-address double write landed on the last edge |

## Verification
A drive machine stuck in `PS_WAKE` or `PS_DARK` shows up as a missing valid mask in the very next read slot. A machine that skips `PS_WAKE` shows up as a driven read in the first slot after a deselect. A capture register off by one stage moves read data one slot early or late, and the directed sequences sample the slot on each side. A corrupted lane merge or priority shows up on the first read-back after the write, two edges later. A faulty collision comparator shows up on `clash` one edge after the offending writes are captured.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int NPORT  = 2;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        PS_DARK = 2'd0,
        PS_WAKE = 2'd1,
        PS_LIVE = 2'd2
    } drive_st_e;
endpackage

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW   = 6,
    parameter int NL   = LANES,
    parameter int LW   = LANE_W,
    localparam int WW  = NL * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] be,
    input  logic [WW-1:0] d,
    input  logic [WW-1:0] rd_word,
    output logic          cap_we,
    output logic [AW-1:0] cap_addr,
    output logic [NL-1:0] cap_be,
    output logic [WW-1:0] cap_d,
    output logic [WW-1:0] q,
    output logic [NL-1:0] qv
);
    logic      cap_sel_q;
    logic      cap_wr_q;
    logic      cap_rd;
    drive_st_e st_q;
    drive_st_e st_nx;

    // input capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sel_q <= 1'b0;
            cap_wr_q  <= 1'b0;
            cap_addr  <= '0;
            cap_be    <= '0;
            cap_d     <= '0;
        end else begin
            cap_sel_q <= !cs_n && cs;
            cap_wr_q  <= wr;
            cap_addr  <= addr;
            cap_be    <= be;
            cap_d     <= d;
        end
    end

    assign cap_we = cap_sel_q && cap_wr_q;
    assign cap_rd = cap_sel_q && !cap_wr_q;

    // drive-enable machine: next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PS_DARK: st_nx = cap_sel_q ? PS_WAKE : PS_DARK;
            PS_WAKE: st_nx = cap_sel_q ? PS_LIVE : PS_DARK;
            PS_LIVE: st_nx = cap_sel_q ? PS_LIVE : PS_DARK;
            default: st_nx = PS_DARK;
        endcase
    end

    // drive-enable machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_DARK;
        else        st_q <= st_nx;
    end

    // output register, per lane
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q  <= '0;
            qv <= '0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                if (st_nx == PS_LIVE && cap_rd && cap_be[l]) begin
                    qv[l]             <= 1'b1;
                    q[l*LW +: LW]     <= rd_word[l*LW +: LW];
                end else begin
                    qv[l]             <= 1'b0;
                    q[l*LW +: LW]     <= '0;
                end
            end
        end
    end

    AST_DESELECT_DARKENS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_sel_q |=> (qv == '0)); // R6
    AST_WAKE_HIDES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_DARK) && cap_sel_q |=> (qv == '0)); // R7
    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (qv != '0) |-> $past(cap_rd)); // R2
    AST_VALID_WITHIN_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (qv != '0) |-> ((qv & ~$past(cap_be)) == '0)); // R5

    for (genvar gl = 0; gl < NL; gl++) begin : g_lane_chk
        AST_UNDRIVEN_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !qv[gl] |-> (q[gl*LW +: LW] == '0)); // R5
    end
endmodule

// File: rtl/dpr_store.sv
module dpr_store
    import dpr_pkg::*;
#(
    parameter int AW   = 6,
    parameter int NP   = NPORT,
    parameter int NL   = LANES,
    parameter int LW   = LANE_W,
    localparam int WW  = NL * LW,
    localparam int DEP = 1 << AW
) (
    input  logic                   clk,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][NL-1:0]  be,
    input  logic [NP-1:0][WW-1:0]  d,
    output logic [NP-1:0][WW-1:0]  rd_word
);
    logic [WW-1:0] mem [DEP];

    // higher index first, so port 0 (A) lands last and wins per lane
    always_ff @(posedge clk) begin
        for (int p = NP - 1; p >= 0; p--) begin
            for (int l = 0; l < NL; l++) begin
                if (we[p] && be[p][l]) begin
                    mem[addr[p]][l*LW +: LW] <= d[p][l*LW +: LW];
                end
            end
        end
    end

    for (genvar gp = 0; gp < NP; gp++) begin : g_rd
        assign rd_word[gp] = mem[addr[gp]];
    end
endmodule

// File: rtl/dpr_clash.sv
module dpr_clash
    import dpr_pkg::*;
#(
    parameter int AW = 6,
    parameter int NP = NPORT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         we,
    input  logic [NP-1:0][AW-1:0] addr,
    output logic                  clash
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NP; i++) begin
            for (int j = i + 1; j < NP; j++) begin
                if (we[i] && we[j] && addr[i] == addr[j]) hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clash <= 1'b0;
        else        clash <= hit;
    end
endmodule

// File: rtl/dpr_pipe_ram.sv
module dpr_pipe_ram
    import dpr_pkg::*;
#(
    parameter int AW  = 6,
    localparam int WW = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_cs,
    input  logic              a_wr,
    input  logic [AW-1:0]     a_addr,
    input  logic [LANES-1:0]  a_be,
    input  logic [WW-1:0]     a_d,
    output logic [WW-1:0]     a_q,
    output logic [LANES-1:0]  a_qv,
    input  logic              b_cs_n,
    input  logic              b_cs,
    input  logic              b_wr,
    input  logic [AW-1:0]     b_addr,
    input  logic [LANES-1:0]  b_be,
    input  logic [WW-1:0]     b_d,
    output logic [WW-1:0]     b_q,
    output logic [LANES-1:0]  b_qv,
    output logic              clash
);
    logic [NPORT-1:0]                in_cs_n, in_cs, in_wr;
    logic [NPORT-1:0][AW-1:0]        in_addr;
    logic [NPORT-1:0][LANES-1:0]     in_be;
    logic [NPORT-1:0][WW-1:0]        in_d;
    logic [NPORT-1:0]                cap_we;
    logic [NPORT-1:0][AW-1:0]        cap_addr;
    logic [NPORT-1:0][LANES-1:0]     cap_be;
    logic [NPORT-1:0][WW-1:0]        cap_d;
    logic [NPORT-1:0][WW-1:0]        rd_word;
    logic [NPORT-1:0][WW-1:0]        out_q;
    logic [NPORT-1:0][LANES-1:0]     out_qv;

    assign in_cs_n = {b_cs_n, a_cs_n};
    assign in_cs   = {b_cs, a_cs};
    assign in_wr   = {b_wr, a_wr};
    assign in_addr = {b_addr, a_addr};
    assign in_be   = {b_be, a_be};
    assign in_d    = {b_d, a_d};

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        dpr_port #(.AW(AW), .NL(LANES), .LW(LANE_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cs_n     (in_cs_n[gp]),
            .cs       (in_cs[gp]),
            .wr       (in_wr[gp]),
            .addr     (in_addr[gp]),
            .be       (in_be[gp]),
            .d        (in_d[gp]),
            .rd_word  (rd_word[gp]),
            .cap_we   (cap_we[gp]),
            .cap_addr (cap_addr[gp]),
            .cap_be   (cap_be[gp]),
            .cap_d    (cap_d[gp]),
            .q        (out_q[gp]),
            .qv       (out_qv[gp])
        );
    end

    dpr_store #(.AW(AW), .NP(NPORT), .NL(LANES), .LW(LANE_W)) u_store (
        .clk     (clk),
        .we      (cap_we),
        .addr    (cap_addr),
        .be      (cap_be),
        .d       (cap_d),
        .rd_word (rd_word)
    );

    dpr_clash #(.AW(AW), .NP(NPORT)) u_clash (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cap_we),
        .addr  (cap_addr),
        .clash (clash)
    );

    assign a_q  = out_q[0];
    assign a_qv = out_qv[0];
    assign b_q  = out_q[1];
    assign b_qv = out_qv[1];

    AST_CLASH_NEEDS_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> $past(cap_we[0] && cap_we[1])); // R10
    AST_CLASH_ONE_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> $past(cap_addr[0] == cap_addr[1])); // R10
endmodule

// File: tb/sim_dpr_pipe_ram.sv
`timescale 1ns/1ps
module sim_dpr_pipe_ram;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_cs_n, a_cs, a_wr, b_cs_n, b_cs, b_wr;
    logic [5:0]  a_addr, b_addr;
    logic [1:0]  a_be, b_be, a_qv, b_qv;
    logic [17:0] a_d, b_d, a_q, b_q;
    logic        clash;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    dpr_pipe_ram #(.AW(6)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_cs(a_cs), .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be),
        .a_d(a_d), .a_q(a_q), .a_qv(a_qv),
        .b_cs_n(b_cs_n), .b_cs(b_cs), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be),
        .b_d(b_d), .b_q(b_q), .b_qv(b_qv),
        .clash(clash)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drv_a(input logic sn, input logic s, input logic w,
                         input logic [5:0] ad, input logic [1:0] e, input logic [17:0] dd);
        a_cs_n = sn; a_cs = s; a_wr = w; a_addr = ad; a_be = e; a_d = dd;
    endtask

    task automatic drv_b(input logic sn, input logic s, input logic w,
                         input logic [5:0] ad, input logic [1:0] e, input logic [17:0] dd);
        b_cs_n = sn; b_cs = s; b_wr = w; b_addr = ad; b_be = e; b_d = dd;
    endtask

    task automatic idle_all();
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);
        drv_b(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);
    endtask

    task automatic chk_a(input string req, input logic [1:0] ev, input logic [17:0] eq);
        n_cmp++;
        if (a_qv !== ev || a_q !== eq) begin
            n_bad++;
            $display("FAIL %s port A: qv=%b q=%h, expected qv=%b q=%h", req, a_qv, a_q, ev, eq);
        end
    endtask

    task automatic chk_b(input string req, input logic [1:0] ev, input logic [17:0] eq);
        n_cmp++;
        if (b_qv !== ev || b_q !== eq) begin
            n_bad++;
            $display("FAIL %s port B: qv=%b q=%h, expected qv=%b q=%h", req, b_qv, b_q, ev, eq);
        end
    endtask

    task automatic chk_clash(input string req, input logic ec);
        n_cmp++;
        if (clash !== ec) begin
            n_bad++;
            $display("FAIL %s clash=%b, expected %b", req, clash, ec);
        end
    endtask

    task automatic t_reset();
        chk_a("R1", 2'b00, 18'h0);
        chk_b("R1", 2'b00, 18'h0);
        chk_clash("R1", 1'b0);
    endtask

    task automatic t_latency();
        drv_a(1'b0, 1'b1, 1'b1, 6'd3, 2'b11, 18'h155AA); step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd3, 2'b11, 18'h0);     step();
        chk_a("R2", 2'b00, 18'h0);       // write slot, read not yet out
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);     step();
        chk_a("R3", 2'b11, 18'h155AA);
        step();
        chk_a("R6", 2'b00, 18'h0);
    endtask

    task automatic t_lanes();
        drv_a(1'b0, 1'b1, 1'b1, 6'd7, 2'b11, 18'h3FFFF); step();
        drv_a(1'b0, 1'b1, 1'b1, 6'd7, 2'b01, 18'h00000); step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0);     step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b10, 18'h0);     step();
        chk_a("R4", 2'b11, 18'h3FE00);
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b01, 18'h0);     step();
        chk_a("R5", 2'b10, 18'h3FE00);
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);     step();
        chk_a("R5", 2'b01, 18'h00000);
        step();
    endtask

    task automatic t_deselect();
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        chk_a("R7", 2'b00, 18'h0);
        drv_a(1'b1, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        chk_a("R3", 2'b11, 18'h3FE00);
        drv_a(1'b0, 1'b0, 1'b0, 6'd7, 2'b11, 18'h0); step();
        chk_a("R6", 2'b00, 18'h0);
        drv_a(1'b1, 1'b1, 1'b1, 6'd7, 2'b11, 18'h0); step();
        chk_a("R6", 2'b00, 18'h0);
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        chk_a("R6", 2'b00, 18'h0);
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        chk_a("R7", 2'b00, 18'h0);
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0); step();
        chk_a("R6", 2'b11, 18'h3FE00); // deselected write left word intact
        step();
    endtask

    task automatic t_dual_read();
        drv_a(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0);
        drv_b(1'b0, 1'b1, 1'b0, 6'd7, 2'b11, 18'h0); step();
        step();
        chk_b("R7", 2'b00, 18'h0);     // first B access since reset
        idle_all(); step();
        chk_a("R8", 2'b11, 18'h3FE00);
        chk_b("R8", 2'b11, 18'h3FE00);
        step();
    endtask

    task automatic t_cross();
        drv_b(1'b0, 1'b1, 1'b1, 6'd9, 2'b11, 18'h11111); step();
        drv_a(1'b0, 1'b1, 1'b1, 6'd9, 2'b11, 18'h0ABCD);
        drv_b(1'b0, 1'b1, 1'b0, 6'd9, 2'b11, 18'h0);     step();
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);     step();
        chk_b("R9", 2'b11, 18'h11111);
        chk_clash("R10", 1'b0);
        drv_b(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);     step();
        chk_b("R9", 2'b11, 18'h0ABCD);
        step();
    endtask

    task automatic t_clash();
        drv_a(1'b0, 1'b1, 1'b1, 6'd11, 2'b11, 18'h3F0F0);
        drv_b(1'b0, 1'b1, 1'b1, 6'd11, 2'b11, 18'h00F0F); step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd11, 2'b11, 18'h0);
        drv_b(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);      step();
        chk_clash("R10", 1'b1);
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);      step();
        chk_clash("R10", 1'b0);
        chk_a("R11", 2'b11, 18'h3F0F0);
        drv_a(1'b0, 1'b1, 1'b1, 6'd12, 2'b01, 18'h00077);
        drv_b(1'b0, 1'b1, 1'b1, 6'd12, 2'b10, 18'h2AA00); step();
        drv_a(1'b0, 1'b1, 1'b0, 6'd12, 2'b11, 18'h0);
        drv_b(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);      step();
        chk_clash("R10", 1'b1);
        drv_a(1'b1, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);      step();
        chk_a("R11", 2'b11, 18'h2AA77);
        drv_a(1'b0, 1'b1, 1'b1, 6'd13, 2'b11, 18'h1);
        drv_b(1'b0, 1'b1, 1'b1, 6'd14, 2'b11, 18'h2);     step();
        idle_all(); step();
        chk_clash("R10", 1'b0);
        drv_a(1'b0, 1'b1, 1'b1, 6'd15, 2'b11, 18'h3);
        drv_b(1'b1, 1'b1, 1'b1, 6'd15, 2'b11, 18'h4);     step();
        idle_all(); step();
        chk_clash("R10", 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_all();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_latency();
        t_lanes();
        t_deselect();
        t_dual_read();
        t_cross();
        t_clash();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule